// File: doc/BRIEF.md
# I2C Register-Access Target

This block is the serial front end of a 16-line port expander. It listens to a two-wire I2C bus, answers to one of 32 seven-bit addresses chosen by a five-bit select code, and gives the bus host byte-wide access to an external bank of 22 eight-bit registers through a plain write strobe and a combinational read port. SCL and SDA enter through synchronizers and spike filters. START, repeated START and STOP are then detected on the clean lines. The only drive the block has on the bus is an open-drain pull-down enable for SDA.

A write transfer carries the address, then a command byte that loads the register pointer, then any number of data bytes. The pointer steps after each byte and wraps at the top of the bank. A read transfer first writes the pointer, then issues a repeated START and the address with the read bit set, and then clocks out bytes until the host answers with NACK. Four status offsets cannot be written. Whenever one of the two pin-state offsets is read, the block emits a one-cycle pulse that carries the offset, so the interrupt logic beside it can clear its pending flags.

Top module: `i2c_regport_target`

## Requirements
- R1: The block acknowledges an address byte whose upper seven bits equal 0x10 plus `addr_sel`. Any other address gets no acknowledge, and the block leaves SDA released until the next START.
- R2: Bit 0 of the address byte selects the direction: 0 starts a write (command byte follows) and 1 starts a read from the current pointer.
- R3: The first byte after a write address loads the register pointer. A value from 0x00 to 0x15 is used as is; any larger value loads 0x00.
- R4: The block pulls SDA low in the acknowledge slot of every accepted address byte, command byte and write data byte.
- R5: Each write data byte produces a one-clock `reg_wr_en` pulse with `reg_wr_addr` equal to the pointer and `reg_wr_data` equal to the byte. The pointer then steps by one and wraps from 0x15 to 0x00.
- R6: Write data aimed at offsets 0x00, 0x01, 0x0E or 0x0F is acknowledged and steps the pointer, but it produces no write strobe and leaves the register unchanged.
- R7: In a read, the block sends the byte at the pointer MSB first and steps the pointer. It keeps sending while the host acknowledges. After a NACK it releases SDA, and SDA changes only while SCL is low.
- R8: Loading a byte from offset 0x00 or 0x01 for transmission raises `state_rd_stb` for exactly one clock, with `state_rd_off` holding that offset. No other offset raises it.
- R9: A level on SCL or SDA that lasts fewer than `FILT_CYC` clocks (6 by default, 60 ns at 100 MHz, so 50 ns spikes are rejected) has no effect on the transfer.
- R10: After reset, and one clock after a STOP, SDA is released, and the write strobe and the state-read pulse are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, well above 16x SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Raw bus clock level |
| sda_in | input | 1 | Raw bus data level |
| addr_sel | input | 5 | Address select code, added to 0x10 |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| reg_wr_en | output | 1 | One-clock register write strobe |
| reg_wr_addr | output | 5 | Offset for the write strobe |
| reg_wr_data | output | 8 | Data for the write strobe |
| reg_rd_addr | output | 5 | Current register pointer, for read data |
| reg_rd_data | input | 8 | Register contents at `reg_rd_addr` |
| state_rd_stb | output | 1 | One-clock pulse when a pin-state offset is read |
| state_rd_off | output | 5 | Offset that caused `state_rd_stb` |

## Verification
The assertions check several rules on every cycle. The filtered line may move only to a level the synchronizer has been holding. SDA drive is frozen while the filtered SCL stays high. SDA is released one clock after any STOP. The write strobe and the state-read pulse never last longer than one clock. Address matching, acknowledge placement, pointer wrap, write suppression for the status offsets, out-of-range command values and spike rejection in the middle of a byte can only be shown by the bench's bus transfers. The bench reads the register contents back over the bus and compares them with its own model.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,     // waiting for START
    ST_RX,       // shifting in a byte on SCL rising edges
    ST_ACK_WAIT, // byte accepted, pull SDA at next SCL fall
    ST_ACK_HOLD, // holding ACK until next SCL fall
    ST_TX,       // shifting out a byte on SCL falling edges
    ST_MACK,     // host acknowledge slot after a sent byte
    ST_LOAD      // host acked, load next byte at SCL fall
  } tgt_state_t;

  typedef enum logic [1:0] {
    BK_ADDR,
    BK_CMD,
    BK_DATA
  } byte_kind_t;
endpackage

// File: rtl/i2c_spike_filter.sv
module i2c_spike_filter #(
  parameter int STABLE_CYC = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  localparam int CW = $clog2(STABLE_CYC) + 1;

  logic [1:0]    sync;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync <= 2'b11;
      dout <= 1'b1;
      cnt  <= '0;
    end else begin
      sync <= {sync[0], din};
      if (sync[1] == dout) begin
        cnt <= '0;
      end else if (cnt == CW'(STABLE_CYC - 1)) begin
        dout <= sync[1];
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R9: the clean line only ever moves to the level the synchronizer held
  a_r9_filter_follows: assert property (@(posedge clk) disable iff (rst)
    (dout != $past(dout)) |-> ($past(sync[1]) == dout));
endmodule

// File: rtl/i2c_line_events.sv
module i2c_line_events (
  input  logic clk,
  input  logic rst,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  assign scl_rise  = scl_f & ~scl_q;
  assign scl_fall  = ~scl_f & scl_q;
  assign start_det = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_det  = scl_f & scl_q & ~sda_q & sda_f;
endmodule

// File: rtl/i2c_tgt_ctrl.sv
module i2c_tgt_ctrl
  import i2c_tgt_pkg::*;
#(
  parameter int              NUM_REGS   = 22,
  parameter logic [NUM_REGS-1:0] RO_MASK    = 22'h00C003,
  parameter logic [NUM_REGS-1:0] STATE_MASK = 22'h000003,
  localparam int             PW         = $clog2(NUM_REGS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_f,
  input  logic          sda_f,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic [6:0]    my_addr,
  output logic          sda_oe,
  output logic          reg_wr_en,
  output logic [PW-1:0] reg_wr_addr,
  output logic [7:0]    reg_wr_data,
  output logic [PW-1:0] reg_rd_addr,
  input  logic [7:0]    reg_rd_data,
  output logic          state_rd_stb,
  output logic [PW-1:0] state_rd_off
);
  localparam int LAST = NUM_REGS - 1;

  tgt_state_t    state;
  byte_kind_t    kind;
  logic [2:0]    bitcnt;
  logic [6:0]    shreg;
  logic [7:0]    txreg;
  logic [PW-1:0] ptr;
  logic          rw;
  logic [7:0]    rx_byte;
  logic [PW-1:0] ptr_nxt;
  logic          do_load;

  assign rx_byte     = {shreg, sda_f};
  assign ptr_nxt     = (ptr == PW'(LAST)) ? '0 : ptr + 1'b1;
  assign reg_rd_addr = ptr;
  assign do_load     = scl_fall && !start_det && !stop_det &&
                       ((state == ST_ACK_HOLD && kind == BK_ADDR && rw) ||
                        state == ST_LOAD);

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      kind         <= BK_ADDR;
      bitcnt       <= '0;
      shreg        <= '0;
      txreg        <= '0;
      ptr          <= '0;
      rw           <= 1'b0;
      sda_oe       <= 1'b0;
      reg_wr_en    <= 1'b0;
      reg_wr_addr  <= '0;
      reg_wr_data  <= '0;
      state_rd_stb <= 1'b0;
      state_rd_off <= '0;
    end else begin
      reg_wr_en    <= 1'b0;
      state_rd_stb <= 1'b0;
      if (stop_det) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else if (start_det) begin
        state  <= ST_RX;
        kind   <= BK_ADDR;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_RX: if (scl_rise) begin
            shreg  <= rx_byte[6:0];
            bitcnt <= bitcnt + 1'b1;
            if (bitcnt == 3'd7) begin
              state <= ST_ACK_WAIT;
              case (kind)
                BK_ADDR: begin
                  if (rx_byte[7:1] == my_addr) rw <= rx_byte[0];
                  else                         state <= ST_IDLE;
                end
                BK_CMD: ptr <= (rx_byte <= 8'(LAST)) ? rx_byte[PW-1:0] : '0;
                default: begin
                  reg_wr_en   <= !RO_MASK[ptr];
                  reg_wr_addr <= ptr;
                  reg_wr_data <= rx_byte;
                  ptr         <= ptr_nxt;
                end
              endcase
            end
          end
          ST_ACK_WAIT: if (scl_fall) begin
            sda_oe <= 1'b1;
            state  <= ST_ACK_HOLD;
          end
          ST_ACK_HOLD: if (scl_fall && !(kind == BK_ADDR && rw)) begin
            sda_oe <= 1'b0;
            state  <= ST_RX;
            kind   <= (kind == BK_ADDR) ? BK_CMD : BK_DATA;
          end
          ST_TX: if (scl_fall) begin
            if (bitcnt == 3'd7) begin
              sda_oe <= 1'b0;
              state  <= ST_MACK;
            end else begin
              txreg  <= txreg << 1;
              sda_oe <= ~txreg[6];
              bitcnt <= bitcnt + 1'b1;
            end
          end
          ST_MACK: if (scl_rise) state <= sda_f ? ST_IDLE : ST_LOAD;
          default: ;
        endcase
        if (do_load) begin
          txreg        <= reg_rd_data;
          sda_oe       <= ~reg_rd_data[7];
          bitcnt       <= '0;
          state        <= ST_TX;
          state_rd_stb <= STATE_MASK[ptr];
          state_rd_off <= ptr;
          ptr          <= ptr_nxt;
        end
      end
    end
  end

  // R10: SDA is let go one clock after a STOP
  a_r10_stop_release: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !sda_oe);
  // R7: the SDA drive never moves while SCL is high
  a_r7_sda_hold: assert property (@(posedge clk) disable iff (rst)
    (scl_f && $past(scl_f)) |-> $stable(sda_oe));
  // R5: write strobe lasts one clock
  a_r5_wr_pulse: assert property (@(posedge clk) disable iff (rst)
    reg_wr_en |=> !reg_wr_en);
  // R8: state-read pulse lasts one clock
  a_r8_one_cycle: assert property (@(posedge clk) disable iff (rst)
    state_rd_stb |=> !state_rd_stb);
endmodule

// File: rtl/i2c_regport_target.sv
module i2c_regport_target #(
  parameter int                  NUM_REGS   = 22,
  parameter int                  SEL_W      = 5,
  parameter logic [6:0]          ADDR_BASE  = 7'h10,
  parameter int                  FILT_CYC   = 6,
  parameter logic [NUM_REGS-1:0] RO_MASK    = 22'h00C003,
  parameter logic [NUM_REGS-1:0] STATE_MASK = 22'h000003,
  localparam int                 PW         = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_in,
  input  logic             sda_in,
  input  logic [SEL_W-1:0] addr_sel,
  output logic             sda_oe,
  output logic             reg_wr_en,
  output logic [PW-1:0]    reg_wr_addr,
  output logic [7:0]       reg_wr_data,
  output logic [PW-1:0]    reg_rd_addr,
  input  logic [7:0]       reg_rd_data,
  output logic             state_rd_stb,
  output logic [PW-1:0]    state_rd_off
);
  logic [1:0] raw_lines;
  logic [1:0] clean_lines;
  logic       scl_rise, scl_fall, start_det, stop_det;
  logic [6:0] my_addr;

  assign raw_lines = {sda_in, scl_in};
  assign my_addr   = ADDR_BASE + 7'(addr_sel);

  for (genvar g = 0; g < 2; g++) begin : g_filt
    i2c_spike_filter #(.STABLE_CYC(FILT_CYC)) u_filt (
      .clk  (clk),
      .rst  (rst),
      .din  (raw_lines[g]),
      .dout (clean_lines[g])
    );
  end

  i2c_line_events u_events (
    .clk       (clk),
    .rst       (rst),
    .scl_f     (clean_lines[0]),
    .sda_f     (clean_lines[1]),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_tgt_ctrl #(
    .NUM_REGS   (NUM_REGS),
    .RO_MASK    (RO_MASK),
    .STATE_MASK (STATE_MASK)
  ) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .scl_f        (clean_lines[0]),
    .sda_f        (clean_lines[1]),
    .scl_rise     (scl_rise),
    .scl_fall     (scl_fall),
    .start_det    (start_det),
    .stop_det     (stop_det),
    .my_addr      (my_addr),
    .sda_oe       (sda_oe),
    .reg_wr_en    (reg_wr_en),
    .reg_wr_addr  (reg_wr_addr),
    .reg_wr_data  (reg_wr_data),
    .reg_rd_addr  (reg_rd_addr),
    .reg_rd_data  (reg_rd_data),
    .state_rd_stb (state_rd_stb),
    .state_rd_off (state_rd_off)
  );
endmodule

// File: tb/i2c_regport_target_test.sv
module i2c_regport_target_test;
  localparam int Q  = 40;   // quarter SCL period in clocks
  localparam int NR = 22;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic [4:0] sel = 5'd0;
  logic       sda_oe, reg_wr_en, state_rd_stb;
  logic [4:0] reg_wr_addr, reg_rd_addr, state_rd_off;
  logic [7:0] reg_wr_data, reg_rd_data;
  logic       sda_line;
  logic [7:0] bank [NR];
  logic [7:0] expv [NR];
  int         checks = 0, fails = 0;
  int         wr_cnt = 0, pulse_cnt = 0, long_pulse = 0;
  logic [NR-1:0] pulse_mask = '0;
  logic       prev_stb = 1'b0;
  bit         done = 0;

  always #5 clk = ~clk;

  assign sda_line    = sda_m & ~sda_oe;
  assign reg_rd_data = (reg_rd_addr < 5'(NR)) ? bank[reg_rd_addr] : 8'h00;

  i2c_regport_target uut (
    .clk(clk), .rst(rst), .scl_in(scl_m), .sda_in(sda_line), .addr_sel(sel),
    .sda_oe(sda_oe), .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr),
    .reg_wr_data(reg_wr_data), .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
    .state_rd_stb(state_rd_stb), .state_rd_off(state_rd_off)
  );

  // external register bank, as the neighbour logic would hold it
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NR; i++) bank[i] <= 8'hA0 + 8'(i);
    end else if (reg_wr_en && reg_wr_addr < 5'(NR)) begin
      bank[reg_wr_addr] <= reg_wr_data;
    end
  end

  always @(negedge clk) begin
    if (reg_wr_en) wr_cnt++;
    if (state_rd_stb) begin
      pulse_cnt++;
      if (state_rd_off < 5'(NR)) pulse_mask[state_rd_off] = 1'b1;
      if (prev_stb) long_pulse++;
    end
    prev_stb = state_rd_stb;
  end

  function automatic bit is_ro(int p);
    return (p == 0) || (p == 1) || (p == 14) || (p == 15);
  endfunction
  function automatic int nxt(int p);
    return (p == NR - 1) ? 0 : p + 1;
  endfunction
  function automatic int ptr_of(logic [7:0] c);
    return (c <= 8'(NR - 1)) ? int'(c) : 0;
  endfunction

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic qwait;
    repeat (Q) @(posedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; qwait; scl_m = 1'b1; qwait;
    sda_m = 1'b0; qwait; scl_m = 1'b0; qwait;
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; qwait; scl_m = 1'b1; qwait; sda_m = 1'b1; qwait;
  endtask

  task automatic send_byte(input logic [7:0] b, input bit glitch, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; qwait; scl_m = 1'b1; qwait;
      if (glitch && i == 5) begin
        scl_m = 1'b0; repeat (3) @(posedge clk); scl_m = 1'b1;
      end
      if (glitch && i == 3 && b[i]) begin
        sda_m = 1'b0; repeat (3) @(posedge clk); sda_m = 1'b1;
      end
      qwait; scl_m = 1'b0; qwait;
    end
    sda_m = 1'b1; qwait; scl_m = 1'b1; qwait;
    acked = (sda_line == 1'b0);
    qwait; scl_m = 1'b0; qwait;
  endtask

  task automatic recv_byte(input bit host_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      qwait; scl_m = 1'b1; qwait; b[i] = sda_line; qwait; scl_m = 1'b0;
    end
    sda_m = host_ack ? 1'b0 : 1'b1;
    qwait; scl_m = 1'b1; qwait; qwait; scl_m = 1'b0; qwait;
    sda_m = 1'b1;
  endtask

  function automatic logic [6:0] dev_addr;
    return 7'h10 + 7'(sel);
  endfunction

  // write n random bytes starting at command c (R3, R4, R5, R6, R9)
  task automatic wr_regs(input logic [7:0] c, input int n, input bit glitch);
    bit ack;
    int p;
    logic [7:0] d;
    bus_start;
    send_byte({dev_addr(), 1'b0}, 1'b0, ack);
    chk(ack, "R1/R4 address ack on write", int'(ack), 1);
    send_byte(c, 1'b0, ack);
    chk(ack, "R4 command ack", int'(ack), 1);
    p = ptr_of(c);
    for (int k = 0; k < n; k++) begin
      d = 8'($urandom);
      if (glitch) d[3] = 1'b1;
      send_byte(d, glitch, ack);
      chk(ack, glitch ? "R9 data ack with spikes" : "R4 data ack", int'(ack), 1);
      if (!is_ro(p)) expv[p] = d;
      p = nxt(p);
    end
    bus_stop;
    chk(sda_oe == 1'b0, "R10 SDA released after stop", int'(sda_oe), 0);
  endtask

  // read n bytes starting at command c via repeated START (R2, R3, R7)
  task automatic rd_regs(input logic [7:0] c, input int n);
    bit ack;
    int p;
    logic [7:0] b;
    bus_start;
    send_byte({dev_addr(), 1'b0}, 1'b0, ack);
    chk(ack, "R4 address ack before read", int'(ack), 1);
    send_byte(c, 1'b0, ack);
    chk(ack, "R3 pointer command ack", int'(ack), 1);
    bus_start;
    send_byte({dev_addr(), 1'b1}, 1'b0, ack);
    chk(ack, "R2 read address ack", int'(ack), 1);
    p = ptr_of(c);
    for (int k = 0; k < n; k++) begin
      recv_byte(k < n - 1, b);
      chk(b == expv[p], $sformatf("R7 read data offset %0h", p), int'(b), int'(expv[p]));
      p = nxt(p);
    end
    chk(sda_oe == 1'b0, "R7 SDA released after NACK", int'(sda_oe), 0);
    bus_stop;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int seed_r;
    int base;
    bit ack;
    seed_r = $urandom(32'd20417);
    for (int i = 0; i < NR; i++) expv[i] = 8'hA0 + 8'(i);
    sel = 5'($urandom);
    repeat (10) @(posedge clk);
    @(negedge clk);
    chk(sda_oe == 1'b0, "R10 reset sda_oe", int'(sda_oe), 0);
    chk(reg_wr_en == 1'b0, "R10 reset write strobe", int'(reg_wr_en), 0);
    chk(state_rd_stb == 1'b0, "R10 reset state pulse", int'(state_rd_stb), 0);
    rst = 1'b0;
    repeat (20) @(posedge clk);

    // basic write then read back
    wr_regs(8'h02, 3, 1'b0);
    rd_regs(8'h02, 3);

    // wrong address: NACK, no writes (R1)
    base = wr_cnt;
    bus_start;
    send_byte({dev_addr() ^ 7'h04, 1'b0}, 1'b0, ack);
    chk(!ack, "R1 foreign address nack", int'(ack), 0);
    send_byte(8'h05, 1'b0, ack);
    chk(!ack, "R1 stays silent after mismatch", int'(ack), 0);
    bus_stop;
    chk(wr_cnt == base, "R1 no write after mismatch", wr_cnt - base, 0);

    // read-only offsets and pointer wrap (R5, R6)
    base = wr_cnt;
    wr_regs(8'h0E, 3, 1'b0);
    chk(wr_cnt - base == 1, "R6 only 0x10 strobed", wr_cnt - base, 1);
    base = wr_cnt;
    wr_regs(8'h14, 5, 1'b0);
    chk(wr_cnt - base == 3, "R5 wrap write count", wr_cnt - base, 3);

    // long read across wrap, pin-state pulses (R7, R8)
    base = pulse_cnt;
    pulse_mask = '0;
    rd_regs(8'h0D, 12);
    chk(pulse_cnt - base == 2, "R8 two state pulses", pulse_cnt - base, 2);
    chk(pulse_mask == 22'h3, "R8 pulse offsets", int'(pulse_mask), 3);
    chk(long_pulse == 0, "R8 pulse width", long_pulse, 0);

    base = pulse_cnt;
    rd_regs(8'h03, 1);
    chk(pulse_cnt == base, "R8 no pulse for offset 3", pulse_cnt - base, 0);

    // out-of-range command loads pointer 0 (R3)
    base = pulse_cnt;
    rd_regs(8'h1C, 1);
    chk(pulse_cnt - base == 1, "R3 out-of-range pointer reads 0x00", pulse_cnt - base, 1);

    // spikes shorter than the filter on SCL and SDA (R9)
    wr_regs(8'h05, 3, 1'b1);
    rd_regs(8'h05, 3);

    // random address select and offsets
    for (int it = 0; it < 2; it++) begin
      int c;
      int n;
      sel = 5'($urandom);
      c = int'($urandom_range(0, NR - 1));
      n = int'($urandom_range(1, 3));
      wr_regs(8'(c), n, 1'b0);
      rd_regs(8'(c), n);
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule